// File: doc/BRIEF.md
# Power-Down Sequencer for a Clock Generator

This block controls entry into and exit from a low-power state of a multi-output clock generator. An active-low, asynchronous power-down request is brought into the reference clock domain through a two-flop synchronizer. When the request is seen, the block first parks every output clock group low. The host, 66 MHz and both PCI groups stop at once. The reference and 48 MHz groups stop after a configurable number of cycles. Only when all outputs are low does the block switch off the PLL (VCO) enable and the crystal oscillator enable.

When the request is released, the oscillators are switched on again, but every output stays low for a fixed, parameterized settling interval. This keeps the wake-up latency bounded. The two stop requests (host/66 MHz and PCI) gate their groups only in normal operation and have no effect while the block is powering down, powered down or settling. The analog PLL and crystal are represented only by their enable signals.

Top module: `pdseq_top`

## Requirements
- R1: While reset is asserted and directly after its release, all six output enables are 0, `vco_en` and `xtal_en` are 1 and `ready` is 0. The block then settles for `SETTLE_CYC` cycles and enters normal operation with `ready` 1.
- R2: `pd_req_n`, `host_stop_n` and `pci_stop_n` each pass through two synchronizer flops. A power-down request takes effect on the third rising clock edge after it is applied.
- R3: `out_en` bit positions are: 0 host, 1 66 MHz, 2 PCI, 3 free-running PCI, 4 reference, 5 48 MHz. On the edge where the request takes effect, bits 0 to 3 drop to 0.
- R4: Bits 4 and 5 remain 1 for `PARK_CYC` cycles after the request takes effect and then drop to 0. The oscillator enables fall one cycle later.
- R5: `vco_en` and `xtal_en` never fall while any output enable is 1, or was 1 in the previous cycle.
- R6: If the request is released while outputs are being parked, the block returns to normal operation without ever dropping `vco_en` or `xtal_en`.
- R7: After release from the powered-down state, `vco_en` and `xtal_en` rise on the third edge. Outputs stay 0 and `ready` stays 0 for `SETTLE_CYC` cycles, so normal operation resumes `SETTLE_CYC`+3 edges after release.
- R8: A new request during settling turns the oscillators off again, three edges after it is applied, without any output enable rising.
- R9: In normal operation, a synchronized low on `host_stop_n` clears bits 0 and 1, and a synchronized low on `pci_stop_n` clears bit 2. Bits 3, 4 and 5 are unaffected by either stop input.
- R10: Outside normal operation, the stop inputs have no effect on `out_en`, `vco_en` or `xtal_en`.
- R11: `ready` is 1 exactly in normal operation. Whenever `ready` is 1, both oscillator enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| host_stop_n | input | 1 | Asynchronous host/66 MHz stop request, active low |
| pci_stop_n | input | 1 | Asynchronous PCI stop request, active low |
| out_en | output | 6 | Per-group output clock enables (bit map in R3) |
| vco_en | output | 1 | PLL VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| ready | output | 1 | Outputs valid, normal operation |

## Verification
The bench releases a power-down request during the parking interval. A design that ignored the release would switch the oscillators off, and one that ranked the park timeout above the release would drop them on the last parking cycle. It re-asserts the request during settling, where a design that went back through parking or kept settling would leave the oscillators on or raise outputs early. It counts the exact wake-up edge from release: an off-by-one settle counter would raise `ready` a cycle early or late. It also toggles the stop inputs while powered down, where a design that let them through would raise enables with the VCO off.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_PARK    = 2'd1,
    ST_OSC_OFF = 2'd2,
    ST_WAKE    = 2'd3
  } pd_state_e;

  localparam int NUM_GRP   = 6;
  localparam int GRP_HOST  = 0;
  localparam int GRP_MID66 = 1;
  localparam int GRP_PCI   = 2;
  localparam int GRP_PCIF  = 3;
  localparam int GRP_REF   = 4;
  localparam int GRP_USB48 = 5;

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/pdseq_cycle_cnt.sv
module pdseq_cycle_cnt #(
  parameter int LIMIT = 3,
  localparam int CW   = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          at_limit
);

  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && (cnt_q != LIMIT_V)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt      = cnt_q;
  assign at_limit = (cnt_q == LIMIT_V);

  p_cnt_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LIMIT_V && !clr) |=> (cnt_q == LIMIT_V));

endmodule

// File: rtl/pdseq_gate.sv
module pdseq_gate
  import pdseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  pd_state_e          state,
  input  logic               park_done,
  input  logic               host_run_s,
  input  logic               pci_run_s,
  output logic [NUM_GRP-1:0] out_en,
  output logic               vco_en,
  output logic               xtal_en,
  output logic               ready
);

  logic in_run;
  logic slow_on;

  assign in_run  = (state == ST_RUN);
  assign slow_on = in_run || ((state == ST_PARK) && !park_done);

  always_comb begin
    out_en            = '0;
    out_en[GRP_HOST]  = in_run && host_run_s;
    out_en[GRP_MID66] = in_run && host_run_s;
    out_en[GRP_PCI]   = in_run && pci_run_s;
    out_en[GRP_PCIF]  = in_run;
    out_en[GRP_REF]   = slow_on;
    out_en[GRP_USB48] = slow_on;
  end

  assign vco_en  = (state != ST_OSC_OFF);
  assign xtal_en = (state != ST_OSC_OFF);
  assign ready   = in_run;

  // R10: stop inputs cannot raise enables outside normal operation
  p_quiet_outside_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OSC_OFF || state == ST_WAKE) |-> (out_en == '0));

  // R9: free-running and slow groups ignore the stop requests
  p_free_groups_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> (out_en[GRP_PCIF] && out_en[GRP_REF] && out_en[GRP_USB48]));

endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int PARK_CYC   = 3,
  parameter int SETTLE_CYC = 40000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_req_n,
  input  logic       host_stop_n,
  input  logic       pci_stop_n,
  output logic [5:0] out_en,
  output logic       vco_en,
  output logic       xtal_en,
  output logic       ready
);

  localparam int SETTLE_LIM = SETTLE_CYC - 1;
  localparam int PCW        = (PARK_CYC < 2) ? 1 : $clog2(PARK_CYC + 1);
  localparam int SCW        = (SETTLE_LIM < 2) ? 1 : $clog2(SETTLE_LIM + 1);

  logic [2:0] sync_vec;
  logic       pd_idle_s;
  logic       host_run_s;
  logic       pci_run_s;

  pd_state_e  state_q;
  pd_state_e  state_d;

  logic [PCW-1:0] park_cnt;
  logic           park_done;
  logic [SCW-1:0] settle_cnt;
  logic           settle_done;

  logic [NUM_GRP-1:0] en_vec;

  pdseq_sync #(
    .WIDTH   (3),
    .RST_VAL (3'b111)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({pci_stop_n, host_stop_n, pd_req_n}),
    .sync_out (sync_vec)
  );

  assign pd_idle_s  = sync_vec[0];
  assign host_run_s = sync_vec[1];
  assign pci_run_s  = sync_vec[2];

  pdseq_cycle_cnt #(
    .LIMIT (PARK_CYC)
  ) u_park_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (state_q != ST_PARK),
    .en       (state_q == ST_PARK),
    .cnt      (park_cnt),
    .at_limit (park_done)
  );

  pdseq_cycle_cnt #(
    .LIMIT (SETTLE_LIM)
  ) u_settle_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (state_q != ST_WAKE),
    .en       (state_q == ST_WAKE),
    .cnt      (settle_cnt),
    .at_limit (settle_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (!pd_idle_s) state_d = ST_PARK;
      end
      ST_PARK: begin
        if (pd_idle_s)      state_d = ST_RUN;
        else if (park_done) state_d = ST_OSC_OFF;
      end
      ST_OSC_OFF: begin
        if (pd_idle_s) state_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (!pd_idle_s)       state_d = ST_OSC_OFF;
        else if (settle_done) state_d = ST_RUN;
      end
      default: state_d = ST_OSC_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAKE;
    end else begin
      state_q <= state_d;
    end
  end

  pdseq_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_q),
    .park_done  (park_done),
    .host_run_s (host_run_s),
    .pci_run_s  (pci_run_s),
    .out_en     (en_vec),
    .vco_en     (vco_en),
    .xtal_en    (xtal_en),
    .ready      (ready)
  );

  assign out_en = en_vec;

  // R5: oscillators drop only after all outputs were already parked
  p_park_before_osc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xtal_en) |-> ((out_en == '0) && ($past(out_en) == '0)));

  p_vco_park_before_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vco_en) |-> ($past(out_en) == '0));

  // R11: ready implies running oscillators
  p_ready_osc_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (vco_en && xtal_en));

  // R7: no output enable while the oscillators are off
  p_no_output_osc_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_en |-> (out_en == '0));

  // R6: release during parking goes straight back to normal operation
  p_abort_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PARK && pd_idle_s) |=> ready);

  // R7: wake interval bounded by an independent run-length counter
  logic [SCW:0] wake_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_len_q <= '0;
    end else if (state_q == ST_WAKE) begin
      if (wake_len_q <= (SCW+1)'(SETTLE_CYC)) wake_len_q <= wake_len_q + 1'b1;
    end else begin
      wake_len_q <= '0;
    end
  end

  p_wake_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_len_q <= (SCW+1)'(SETTLE_CYC));

endmodule

// File: tb/pdseq_top_tb_top.sv
module pdseq_top_tb_top;

  localparam int PARK   = 3;
  localparam int SETTLE = 12;
  localparam int NVEC   = 11;

  logic       clk;
  logic       rst_n;
  logic       pd_req_n;
  logic       host_stop_n;
  logic       pci_stop_n;
  logic [5:0] out_en;
  logic       vco_en;
  logic       xtal_en;
  logic       ready;

  int checks;
  int errors;

  pdseq_top #(
    .PARK_CYC   (PARK),
    .SETTLE_CYC (SETTLE)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_req_n    (pd_req_n),
    .host_stop_n (host_stop_n),
    .pci_stop_n  (pci_stop_n),
    .out_en      (out_en),
    .vco_en      (vco_en),
    .xtal_en     (xtal_en),
    .ready       (ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {pd_n, host_n, pci_n, wait[7:0], exp_en[5:0], vco, xtal, ready}
  localparam logic [19:0] VEC [NVEC] = '{
    {3'b111, 8'd3,  6'h3F, 3'b111},  // R9 all running
    {3'b101, 8'd3,  6'h3C, 3'b111},  // R9 host stop
    {3'b110, 8'd3,  6'h3B, 3'b111},  // R9 pci stop
    {3'b111, 8'd3,  6'h3F, 3'b111},  // R9 resume
    {3'b011, 8'd3,  6'h30, 3'b110},  // R3 fast groups parked
    {3'b011, 8'd3,  6'h00, 3'b110},  // R4 slow groups parked
    {3'b000, 8'd1,  6'h00, 3'b000},  // R4 oscillators off
    {3'b000, 8'd10, 6'h00, 3'b000},  // R10 stops ignored
    {3'b111, 8'd3,  6'h00, 3'b110},  // R7 oscillators back
    {3'b111, 8'd11, 6'h00, 3'b110},  // R7 still settling
    {3'b111, 8'd1,  6'h3F, 3'b111}   // R7 ready at SETTLE+3
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1, 2, 3: return "R9";
      4:          return "R3";
      5, 6:       return "R4";
      7:          return "R10";
      default:    return "R7";
    endcase
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [5:0] e_en, logic e_vco,
                       logic e_xtal, logic e_rdy);
    checks++;
    if (out_en !== e_en || vco_en !== e_vco || xtal_en !== e_xtal ||
        ready !== e_rdy) begin
      errors++;
      $display("FAIL %s: got en=%h vco=%b xtal=%b rdy=%b exp en=%h vco=%b xtal=%b rdy=%b",
               tag, out_en, vco_en, xtal_en, ready, e_en, e_vco, e_xtal, e_rdy);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run exp completion");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    pd_req_n = 1'b1;
    host_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    step(3);
    check("R1 in reset", 6'h00, 1'b1, 1'b1, 1'b0);
    rst_n = 1'b1;
    check("R1 after release", 6'h00, 1'b1, 1'b1, 1'b0);
    step(SETTLE - 1);
    check("R1 settling", 6'h00, 1'b1, 1'b1, 1'b0);
    step(1);
    check("R1 ready", 6'h3F, 1'b1, 1'b1, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      pd_req_n    = VEC[i][19];
      host_stop_n = VEC[i][18];
      pci_stop_n  = VEC[i][17];
      step(int'(VEC[i][16:9]));
      check(vec_tag(i), VEC[i][8:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R2: request not visible before the third edge
    pd_req_n = 1'b0;
    step(2);
    check("R2 two edges", 6'h3F, 1'b1, 1'b1, 1'b1);
    step(2);
    check("R6 parking", 6'h30, 1'b1, 1'b1, 1'b0);
    // R6: release inside the parking window
    pd_req_n = 1'b1;
    step(1);
    check("R6 abort e1", 6'h30, 1'b1, 1'b1, 1'b0);
    step(1);
    check("R6 abort e2", 6'h00, 1'b1, 1'b1, 1'b0);
    step(1);
    check("R6 back to run", 6'h3F, 1'b1, 1'b1, 1'b1);

    // R8: power down, release, then request again mid-settle
    pd_req_n = 1'b0;
    step(3 + PARK + 1);
    check("R8 off", 6'h00, 1'b0, 1'b0, 1'b0);
    pd_req_n = 1'b1;
    step(3 + 5);
    check("R8 settling", 6'h00, 1'b1, 1'b1, 1'b0);
    pd_req_n = 1'b0;
    step(2);
    check("R8 still on", 6'h00, 1'b1, 1'b1, 1'b0);
    step(1);
    check("R8 off again", 6'h00, 1'b0, 1'b0, 1'b0);
    pd_req_n = 1'b1;
    step(SETTLE + 2);
    check("R7 one edge early", 6'h00, 1'b1, 1'b1, 1'b0);
    step(1);
    check("R7 full settle", 6'h3F, 1'b1, 1'b1, 1'b1);

    finish_run();
  end

endmodule